// File: doc/BRIEF.md
# Stored-Vector Apply and Compare Engine

This block is the core of a small digital tester. A table holds one entry per tester cycle. For every channel, an entry holds four bits: a drive value, an expected value, a compare-select bit and a care bit. After a start pulse the engine walks the table from index 0 up to a programmed last index, one entry per clock.

On each cycle the engine drives the channels that the entry marks as forced and releases the channels it marks as compared. Any channel can be forced on one cycle and compared on the next. At the end of the cycle the engine strobes the device response on the compared channels and checks it against the expected bits. It keeps a sticky fail flag, the index of the first failing vector and the mask of the channels that failed on that vector.

The table is loaded through a single write port. Drive levels and other analog pin behaviour are outside this block.

Top module: `vtc_engine`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done`, `fail`, `cur_vld` and every bit of `pin_oe` are 0.
- R2: A `start` pulse while idle raises `busy` on the next clock. Entries 0, 1, … up to `last_idx` (sampled at start) are then applied one per clock in increasing order, each shown on `cur_idx` with `cur_vld` high, so a full run applies `last_idx`+1 vectors.
- R3: On an applied cycle, a channel with compare-select 0 has `pin_oe`=1 and `pin_out` equal to its drive bit. A channel with compare-select 1 has `pin_oe`=0 and `pin_out`=0 for that whole cycle. When no vector is applied, all `pin_oe` bits are 0.
- R4: At the clock edge that ends an applied cycle, every channel with compare-select 1 and care 1 whose `pin_in` differs from its expected bit is a mismatch, and any mismatch sets `fail`.
- R5: A channel with care 0, or with compare-select 0, never causes a mismatch, whatever its expected bit.
- R6: On the first mismatching vector of a run, `fail_idx` takes that vector's index and `fail_mask` takes its set of mismatching channels (bit i = channel i). Later mismatches in the same run do not change them.
- R7: With `stop_on_fail`=0 the run always goes through to `last_idx`. After the last compare, `busy` falls and `done` rises in the same cycle, and `done` stays high until the next start.
- R8: With `stop_on_fail`=1 (sampled at start), the run ends at the strobe of the first mismatching vector: `busy` falls, `done` rises, and no further vector is applied.
- R9: An accepted start clears `fail`, `fail_idx`, `fail_mask` and `done`, so a passing run after a failing one reports `fail`=0.
- R10: A write with `wr_en`=1 stores the drive, expected, compare-select and care vectors at `wr_addr`, and a later run applies and checks exactly those values.
- R11: `last_idx`=0 applies only entry 0, and `last_idx` equal to the top table address applies the whole table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW | Table write address |
| wr_drive | input | NCH | Drive bits for the entry |
| wr_expect | input | NCH | Expected bits for the entry |
| wr_cmp | input | NCH | Compare-select bits (1 = compare, 0 = force) |
| wr_care | input | NCH | Care bits (0 = don't care) |
| start | input | 1 | Run start pulse |
| stop_on_fail | input | 1 | End the run at the first mismatch |
| last_idx | input | AW | Index of the last vector of the run |
| pin_in | input | NCH | Sampled channel levels |
| pin_out | output | NCH | Channel drive values |
| pin_oe | output | NCH | Channel output enables |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | At least one mismatch in this run |
| fail_idx | output | AW | Index of the first failing vector |
| fail_mask | output | NCH | Failing channels of that vector |
| cur_vld | output | 1 | A vector is being applied this cycle |
| cur_idx | output | AW | Index of the vector being applied |

## Verification
The assertions assume three things about the inputs. `start` is only pulsed while idle, or else ignored. `pin_in` is settled before the strobe edge. The table is not rewritten during a run. The bench loads the table only between runs. It gives `start` a single-cycle pulse at a falling edge. Its device model derives `pin_in` combinationally from `pin_out` and `pin_oe`, so the response is stable well before each rising edge. Random tables, random injected mismatches and random run lengths stay inside these assumptions, while directed cases cover index 0, the top index and stop-on-fail.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  typedef enum logic [0:0] {
    RUN_IDLE = 1'b0,
    RUN_STEP = 1'b1
  } run_state_t;
endpackage

// File: rtl/vtc_table.sv
module vtc_table #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NCH-1:0] wr_drive,
  input  logic [NCH-1:0] wr_expect,
  input  logic [NCH-1:0] wr_cmp,
  input  logic [NCH-1:0] wr_care,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [NCH-1:0] q_drive,
  output logic [NCH-1:0] q_expect,
  output logic [NCH-1:0] q_cmp,
  output logic [NCH-1:0] q_care
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = 4 * NCH;

  logic [EW-1:0] store [DEPTH];
  logic [EW-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= {wr_care, wr_cmp, wr_expect, wr_drive};
  end

  // synchronous read: the read register is also the apply register
  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= store[rd_addr];
  end

  assign q_drive  = rd_word[0*NCH +: NCH];
  assign q_expect = rd_word[1*NCH +: NCH];
  assign q_cmp    = rd_word[2*NCH +: NCH];
  assign q_care   = rd_word[3*NCH +: NCH];
endmodule

// File: rtl/vtc_seq.sv
module vtc_seq
  import vtc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop_on_fail,
  input  logic [AW-1:0] last_idx,
  input  logic          mis_evt,
  output logic          run_go,
  output logic          run_stop,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          app_vld,
  output logic [AW-1:0] app_idx,
  output logic          busy,
  output logic          done
);
  run_state_t    st;
  logic          issuing;
  logic [AW-1:0] issue_idx;
  logic [AW-1:0] last_q;
  logic          abort;
  logic          finish;

  function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] i);
    return i + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  assign run_go  = (st == RUN_IDLE) && start;
  assign abort   = (st == RUN_STEP) && mis_evt && run_stop;
  assign finish  = (st == RUN_STEP) && app_vld && (app_idx == last_q);
  assign rd_en   = issuing;
  assign rd_addr = issue_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RUN_IDLE;
      issuing   <= 1'b0;
      issue_idx <= '0;
      last_q    <= '0;
      run_stop  <= 1'b0;
      app_vld   <= 1'b0;
      app_idx   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else if (st == RUN_IDLE) begin
      app_vld <= 1'b0;
      if (start) begin
        st        <= RUN_STEP;
        issuing   <= 1'b1;
        issue_idx <= '0;
        last_q    <= last_idx;
        run_stop  <= stop_on_fail;
        busy      <= 1'b1;
        done      <= 1'b0;
      end
    end else if (abort || finish) begin
      st      <= RUN_IDLE;
      issuing <= 1'b0;
      app_vld <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b1;
    end else begin
      app_vld <= issuing;
      app_idx <= issue_idx;
      if (issuing) begin
        if (issue_idx == last_q) issuing <= 1'b0;
        else issue_idx <= step_idx(issue_idx);
      end
    end
  end
endmodule

// File: rtl/vtc_cmp.sv
module vtc_cmp #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_go,
  input  logic           app_vld,
  input  logic [AW-1:0]  app_idx,
  input  logic [NCH-1:0] q_expect,
  input  logic [NCH-1:0] q_cmp,
  input  logic [NCH-1:0] q_care,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] mis_bits,
  output logic           mis_evt,
  output logic           fail,
  output logic [AW-1:0]  fail_idx,
  output logic [NCH-1:0] fail_mask
);
  function automatic logic [NCH-1:0] miss_of(input logic [NCH-1:0] seen,
                                              input logic [NCH-1:0] expv,
                                              input logic [NCH-1:0] sel,
                                              input logic [NCH-1:0] care);
    return sel & care & (seen ^ expv);
  endfunction

  assign mis_bits = app_vld ? miss_of(pin_in, q_expect, q_cmp, q_care) : '0;
  assign mis_evt  = |mis_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_idx  <= '0;
      fail_mask <= '0;
    end else if (run_go) begin
      fail      <= 1'b0;
      fail_idx  <= '0;
      fail_mask <= '0;
    end else if (mis_evt && !fail) begin
      fail      <= 1'b1;
      fail_idx  <= app_idx;
      fail_mask <= mis_bits;
    end
  end
endmodule

// File: rtl/vtc_drive.sv
module vtc_drive #(
  parameter int NCH = 16
) (
  input  logic           app_vld,
  input  logic [NCH-1:0] q_drive,
  input  logic [NCH-1:0] q_cmp,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe
);
  function automatic logic [NCH-1:0] force_en(input logic v, input logic [NCH-1:0] sel);
    return v ? ~sel : '0;
  endfunction

  assign pin_oe  = force_en(app_vld, q_cmp);
  assign pin_out = q_drive & pin_oe;
endmodule

// File: rtl/vtc_engine.sv
module vtc_engine #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NCH-1:0] wr_drive,
  input  logic [NCH-1:0] wr_expect,
  input  logic [NCH-1:0] wr_cmp,
  input  logic [NCH-1:0] wr_care,
  input  logic           start,
  input  logic           stop_on_fail,
  input  logic [AW-1:0]  last_idx,
  input  logic [NCH-1:0] pin_in,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic [AW-1:0]  fail_idx,
  output logic [NCH-1:0] fail_mask,
  output logic           cur_vld,
  output logic [AW-1:0]  cur_idx
);
  logic           run_go, run_stop, rd_en, app_vld, mis_evt;
  logic [AW-1:0]  rd_addr, app_idx;
  logic [NCH-1:0] q_drive, q_expect, q_cmp, q_care, mis_bits;

  vtc_table #(.NCH(NCH), .AW(AW)) u_table (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_drive(wr_drive),
    .wr_expect(wr_expect), .wr_cmp(wr_cmp), .wr_care(wr_care),
    .rd_en(rd_en), .rd_addr(rd_addr), .q_drive(q_drive),
    .q_expect(q_expect), .q_cmp(q_cmp), .q_care(q_care)
  );

  vtc_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_on_fail(stop_on_fail),
    .last_idx(last_idx), .mis_evt(mis_evt), .run_go(run_go),
    .run_stop(run_stop), .rd_en(rd_en), .rd_addr(rd_addr),
    .app_vld(app_vld), .app_idx(app_idx), .busy(busy), .done(done)
  );

  vtc_drive #(.NCH(NCH)) u_drive (
    .app_vld(app_vld), .q_drive(q_drive), .q_cmp(q_cmp),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  vtc_cmp #(.NCH(NCH), .AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run_go(run_go), .app_vld(app_vld),
    .app_idx(app_idx), .q_expect(q_expect), .q_cmp(q_cmp), .q_care(q_care),
    .pin_in(pin_in), .mis_bits(mis_bits), .mis_evt(mis_evt), .fail(fail),
    .fail_idx(fail_idx), .fail_mask(fail_mask)
  );

  assign cur_vld = app_vld;
  assign cur_idx = app_idx;
endmodule

// File: rtl/vtc_engine_chk.sv
module vtc_engine_chk #(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [NCH-1:0] pin_out,
  input logic [NCH-1:0] pin_oe,
  input logic           busy,
  input logic           done,
  input logic           fail,
  input logic [AW-1:0]  fail_idx,
  input logic [NCH-1:0] fail_mask,
  input logic           cur_vld,
  input logic [AW-1:0]  cur_idx,
  input logic           mis_evt,
  input logic           run_stop
);
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_vld |-> pin_oe == '0);

  // R3
  released_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2
  index_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vld && $past(cur_vld) |-> cur_idx == $past(cur_idx) + 1'b1);

  // R2
  apply_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vld |-> busy);

  // R4
  mismatch_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mis_evt |=> fail);

  // R6
  first_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail && $stable(fail_idx) && $stable(fail_mask));

  // R6
  fail_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> fail_mask != '0);

  // R8
  stop_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mis_evt && run_stop |=> !busy && done && !cur_vld);
endmodule

bind vtc_engine vtc_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pin_out(pin_out),
  .pin_oe(pin_oe), .busy(busy), .done(done), .fail(fail),
  .fail_idx(fail_idx), .fail_mask(fail_mask), .cur_vld(cur_vld),
  .cur_idx(cur_idx), .mis_evt(mis_evt), .run_stop(run_stop)
);

// File: tb/sim_vtc_engine.sv
module sim_vtc_engine;
  localparam int NCH   = 16;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [NCH-1:0] SALT = 16'hA5C3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [NCH-1:0] wr_drive = '0, wr_expect = '0, wr_cmp = '0, wr_care = '0;
  logic           start = 1'b0, stop_on_fail = 1'b0;
  logic [AW-1:0]  last_idx = '0;
  logic [NCH-1:0] pin_in, pin_out, pin_oe, fail_mask, dev_rsp;
  logic           busy, done, fail, cur_vld;
  logic [AW-1:0]  fail_idx, cur_idx;

  logic [NCH-1:0] t_drv [DEPTH];
  logic [NCH-1:0] t_exp [DEPTH];
  logic [NCH-1:0] t_cmp [DEPTH];
  logic [NCH-1:0] t_care[DEPTH];

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b0;
  int mon_err = 0, mon_cnt = 0, mon_next = 0, ord_err = 0;

  always #2 clk = ~clk;

  // device model: echoes its driven pins rotated, salted
  assign dev_rsp = {pin_out[NCH-2:0], pin_out[NCH-1]} ^ SALT;
  assign pin_in  = (pin_oe & pin_out) | (~pin_oe & dev_rsp);

  vtc_engine #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_drive(wr_drive), .wr_expect(wr_expect), .wr_cmp(wr_cmp),
    .wr_care(wr_care), .start(start), .stop_on_fail(stop_on_fail),
    .last_idx(last_idx), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .busy(busy), .done(done), .fail(fail),
    .fail_idx(fail_idx), .fail_mask(fail_mask), .cur_vld(cur_vld),
    .cur_idx(cur_idx)
  );

  function automatic logic [NCH-1:0] resp_of(input logic [NCH-1:0] d, input logic [NCH-1:0] c);
    logic [NCH-1:0] p;
    p = d & ~c;
    return {p[NCH-2:0], p[NCH-1]} ^ SALT;
  endfunction

  function automatic logic [NCH-1:0] bad_bits(input int v);
    return t_cmp[v] & t_care[v] & (resp_of(t_drv[v], t_cmp[v]) ^ t_exp[v]);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (cur_vld) begin
        if (int'(cur_idx) != mon_next) ord_err++;
        if (pin_oe !== ~t_cmp[cur_idx]) mon_err++;
        if (pin_out !== (t_drv[cur_idx] & ~t_cmp[cur_idx])) mon_err++;
        mon_next = int'(cur_idx) + 1;
        mon_cnt++;
      end else if (pin_oe !== '0) mon_err++;
    end
  end

  task automatic put(input int a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a);
    wr_drive = t_drv[a]; wr_expect = t_exp[a]; wr_cmp = t_cmp[a]; wr_care = t_care[a];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic make(input int a, input bit consistent);
    t_drv[a]  = NCH'($urandom);
    t_cmp[a]  = NCH'($urandom);
    t_care[a] = NCH'($urandom) | NCH'($urandom);
    t_exp[a]  = consistent ? resp_of(t_drv[a], t_cmp[a]) : NCH'($urandom);
  endtask

  task automatic inject(input int a, input int ch);
    t_cmp[a][ch]  = 1'b1;
    t_care[a][ch] = 1'b1;
    t_exp[a]      = resp_of(t_drv[a], t_cmp[a]);
    t_exp[a][ch]  = ~t_exp[a][ch];
    put(a);
  endtask

  task automatic run(input int last, input bit stp, input string tag);
    int ffi, tmo, exp_cnt;
    logic [NCH-1:0] fm;
    ffi = -1; fm = '0;
    for (int v = 0; v <= last; v++)
      if (ffi < 0 && bad_bits(v) != '0) begin ffi = v; fm = bad_bits(v); end
    exp_cnt = (stp && ffi >= 0) ? ffi + 1 : last + 1;
    mon_err = 0; mon_cnt = 0; mon_next = 0; ord_err = 0;
    @(negedge clk);
    start = 1'b1; stop_on_fail = stp; last_idx = AW'(last); mon_on = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, {tag, " R2 busy after start"}, busy, 1);
    tmo = 0;
    while (done !== 1'b1 && tmo < 2000) begin @(negedge clk); tmo++; end
    mon_on = 1'b0;
    chk(tmo < 2000, {tag, " R7 run ends"}, tmo, 0);
    chk(busy === 1'b0, {tag, " R7 busy low at done"}, busy, 0);
    chk(mon_cnt == exp_cnt, {tag, " R2/R8/R11 vectors applied"}, mon_cnt, exp_cnt);
    chk(ord_err == 0, {tag, " R2 index order"}, ord_err, 0);
    chk(mon_err == 0, {tag, " R3 drive/release per channel"}, mon_err, 0);
    chk(fail === (ffi >= 0), {tag, " R4/R5/R9 fail flag"}, fail, ffi >= 0);
    if (ffi >= 0) begin
      chk(int'(fail_idx) == ffi, {tag, " R6 first fail index"}, fail_idx, ffi);
      chk(fail_mask === fm, {tag, " R6 fail mask"}, fail_mask, fm);
    end
  endtask

  initial begin
    #700000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && fail === 0 && cur_vld === 0 && pin_oe === '0,
        "R1 reset state", {busy, done, fail, cur_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && pin_oe === '0, "R1 after release", pin_oe, 0);

    // R10 load a fully consistent table: everything passes
    for (int a = 0; a < DEPTH; a++) begin make(a, 1'b1); put(a); end
    run(DEPTH - 1, 1'b0, "full-pass R10 R11");

    // R5: flip expected bits only where they are not checked
    for (int a = 0; a < DEPTH; a++) begin
      t_exp[a] = t_exp[a] ^ (NCH'($urandom) & ~(t_cmp[a] & t_care[a]));
      put(a);
    end
    run(DEPTH - 1, 1'b0, "dontcare R5");

    // R6/R7: real mismatches at 37 and 90, run continues
    inject(37, 3);
    inject(90, 11);
    run(DEPTH - 1, 1'b0, "mis-continue R6 R7");
    // R8: stop at first mismatch
    run(DEPTH - 1, 1'b1, "mis-stop R8");
    // R9: short passing run after a failing one
    run(20, 1'b0, "clear R9");
    chk(fail === 1'b0 && fail_mask === '0, "R9 results cleared", fail_mask, 0);
    // R11 single vector, then single failing vector 0 with stop
    run(0, 1'b0, "single R11");
    inject(0, 0);
    run(0, 1'b1, "single-fail R11 R8");
    // mismatch on the very last entry
    inject(DEPTH - 1, NCH - 1);
    for (int a = 0; a < DEPTH - 1; a++)
      if (bad_bits(a) != '0) begin t_exp[a] = resp_of(t_drv[a], t_cmp[a]); put(a); end
    run(DEPTH - 1, 1'b1, "last-fail R11 R6");

    // constrained random runs
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < 64; a++) begin
        int ad;
        ad = int'($urandom_range(DEPTH - 1, 0));
        make(ad, ($urandom_range(9, 0) != 0));
        put(ad);
      end
      run(int'($urandom_range(DEPTH - 1, 0)), bit'($urandom_range(1, 0)), "random R4 R6");
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule